// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block sits between a host's active-low memory controls (chip select, write strobe, read enable) and an external 8K x 8 memory array. It decodes each access into an array write strobe or a gated read path, and it shuts the array off cleanly when a supply comparator signals that power is failing. The comparator output is asynchronous, so it passes through a two-stage synchronizer first. All timer lengths are derived from a clock-frequency parameter.

When the synchronized power-fail flag rises and no access is open, the block protects the array at once. If the host has chip select low at that edge, the open access may finish first. A write finishes when its strobe or chip select rises. A read finishes when chip select rises. If the access is still open after a bounded drain time (nominally 100 us), protection is forced. After power returns, writes stay blocked for a recovery interval (nominally 80 ms). During that interval reads are served but writes are not. A new power-fail during recovery abandons it, and the next power-up restarts the whole count. The `writeOk` output reports whether array writes are currently permitted.

Top module: `pwrfail_guard`

## Requirements
- R1: While reset is asserted and afterwards while `pwrFail` stays high, `writeOk`, `arrWe` and `dataOe` are 0, and `dataOut` is 0.
- R2: In the protected state every host control input is ignored: no combination of `ceN`, `weN` and `oeN` raises `arrWe` or `dataOe`.
- R3: After `pwrFail` falls, `writeOk` rises exactly WPT-independent `CER_CYC + 3` clock edges later (two synchronizer edges, one decision edge, then `CER_CYC` recovery cycles, where `CER_CYC = CLK_HZ*CER_MS/1000`). Until then `arrWe` stays 0 even with `ceN` and `weN` low.
- R4: During the recovery interval a read (`ceN`=0, `weN`=1, `oeN`=0) drives `dataOe`=1 and `dataOut` = `arrRdata`.
- R5: With writes allowed, `arrWe` is 1 exactly when `ceN` and `weN` are both 0, whatever `oeN` is. `arrAddr` follows `addr` and `arrWdata` follows `dataIn`.
- R6: With reads allowed, `dataOe` is 1 only when `ceN`=0, `weN`=1 and `oeN`=0, apart from the R7 exception. `dataOut` equals `arrRdata` when `dataOe` is 1 and is 0 otherwise. Standby (`ceN`=1) and output-disable (`weN`=`oeN`=1) leave `dataOe` at 0.
- R7: If `weN` is already low at the clock edge where `ceN` is first sampled low, `dataOe` stays 0 until `ceN` has been sampled high again.
- R8: If `pwrFail` rises while `ceN` is high, `writeOk` is still 1 after the second clock edge and drops to 0 after the third.
- R9: If `ceN` and `weN` are low at the third edge after `pwrFail` rises, that write continues (`arrWe`=1, `writeOk`=1). Protection applies at the first edge that samples `weN` or `ceN` high.
- R10: If that write never ends, `writeOk` and `arrWe` fall after edge `WPT_CYC + 3`, where `WPT_CYC = CLK_HZ*WPT_US/1000000`. They are still 1 after edge `WPT_CYC + 2`.
- R11: If the open access at power-fail is a read, `writeOk` falls after the third edge and `arrWe` stays 0. `dataOe` stays 1 until an edge samples `ceN` high, and the block is then protected.
- R12: A `pwrFail` rise during recovery keeps `writeOk` at 0, and the next fall restarts the full R3 count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of frequency CLK_HZ |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrFail | input | 1 | Asynchronous power-fail flag from the supply comparator |
| ceN | input | 1 | Host chip select, active low |
| weN | input | 1 | Host write strobe, active low |
| oeN | input | 1 | Host read enable, active low |
| addr | input | ADDR_W | Host address |
| dataIn | input | DATA_W | Host write data |
| dataOut | output | DATA_W | Read data to host, 0 when not driven |
| dataOe | output | 1 | Host data bus drive enable (0 = high impedance) |
| arrAddr | output | ADDR_W | Address to the array |
| arrWdata | output | DATA_W | Write data to the array |
| arrWe | output | 1 | Array write strobe, active high |
| arrRdata | input | DATA_W | Read data from the array |
| writeOk | output | 1 | Writes currently permitted |

## Verification
The bench builds the block with CLK_HZ = 100000 and keeps the default timeouts. That gives a 10-cycle drain window and an 8000-cycle recovery interval. Both are short enough to walk through several full power cycles and to hit the exact edge where the drain times out, on both sides of it. At that scale the edge-exact counts of R3, R8 and R10 can be checked directly. Recovery can also be aborted midway and then rerun in full.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [1:0] {
    ST_PROT    = 2'd0,
    ST_RECOVER = 2'd1,
    ST_RUN     = 2'd2,
    ST_DRAIN   = 2'd3
  } pfg_state_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } pfg_strobe_t;

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] stageQ;

  // Reset to ones: the supply is treated as failed until proven good.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '1;
    else       stageQ <= {stageQ[STAGES-2:0], asyncIn};
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/pfg_ctrl.sv
module pfg_ctrl
  import pfg_pkg::*;
#(
  parameter longint CLK_HZ = 200000000,
  parameter int     WPT_US = 100,
  parameter int     CER_MS = 80
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pfSync,
  input  logic        ceN,
  input  logic        weN,
  output pfg_strobe_t strb
);
  localparam longint WPT_RAW = (CLK_HZ * WPT_US) / 1000000;
  localparam longint CER_RAW = (CLK_HZ * CER_MS) / 1000;
  localparam longint WPT_CYC = (WPT_RAW < 1) ? 1 : WPT_RAW;
  localparam longint CER_CYC = (CER_RAW < 1) ? 1 : CER_RAW;
  localparam longint MAX_CYC = (WPT_CYC > CER_CYC) ? WPT_CYC : CER_CYC;
  localparam int     CNT_W   = $clog2(MAX_CYC + 1);

  pfg_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             drainIsWrite;
  logic             cntZero;
  logic             accessDone;

  assign cntZero    = (cnt == '0);
  assign accessDone = ceN || (drainIsWrite && weN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_PROT;
      cnt          <= '0;
      drainIsWrite <= 1'b0;
    end else begin
      unique case (state)
        ST_PROT: begin
          if (!pfSync) begin
            state <= ST_RECOVER;
            cnt   <= CNT_W'(CER_CYC - 1);
          end
        end
        ST_RECOVER: begin
          if (pfSync)       state <= ST_PROT;
          else if (cntZero) state <= ST_RUN;
          else              cnt   <= cnt - 1'b1;
        end
        ST_RUN: begin
          if (pfSync) begin
            if (!ceN) begin
              state        <= ST_DRAIN;
              cnt          <= CNT_W'(WPT_CYC - 1);
              drainIsWrite <= !weN;
            end else begin
              state <= ST_PROT;
            end
          end
        end
        ST_DRAIN: begin
          if (accessDone || cntZero) state <= ST_PROT;
          else                       cnt   <= cnt - 1'b1;
        end
        default: state <= ST_PROT;
      endcase
    end
  end

  always_comb begin
    strb.rdEn = (state != ST_PROT);
    strb.wrEn = (state == ST_RUN) || (state == ST_DRAIN && drainIsWrite);
  end

  // R12
  recover_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER && pfSync) |=> (state == ST_PROT));

  // R10
  drain_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN) |-> (cnt < CNT_W'(WPT_CYC)));

  // R8
  idle_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && pfSync && ceN) |=> !strb.wrEn);

  // R2
  prot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROT && pfSync) |=> (state == ST_PROT && !strb.wrEn && !strb.rdEn));

  // R3
  write_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.wrEn) |-> ($past(state) == ST_RECOVER && $past(cnt) == '0));
endmodule

// File: rtl/pfg_datapath.sv
module pfg_datapath
  import pfg_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfg_strobe_t       strb,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrWdata,
  output logic              arrWe,
  input  logic [DATA_W-1:0] arrRdata
);
  logic ceNPrev;
  logic holdHiz;
  logic readMode;
  logic writeMode;

  // A cycle whose select falls while the strobe is already low keeps the
  // bus undriven until select has been seen high again.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceNPrev <= 1'b1;
      holdHiz <= 1'b0;
    end else begin
      ceNPrev <= ceN;
      if (ceN)                 holdHiz <= 1'b0;
      else if (ceNPrev && !weN) holdHiz <= 1'b1;
    end
  end

  assign writeMode = !ceN && !weN;
  assign readMode  = !ceN && weN && !oeN;

  assign arrWe    = strb.wrEn && writeMode;
  assign dataOe   = strb.rdEn && readMode && !holdHiz;
  assign dataOut  = dataOe ? arrRdata : '0;
  assign arrAddr  = addr;
  assign arrWdata = dataIn;

  // R7
  late_select_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceNPrev && !ceN && !weN) ##1 (!ceN) |-> !dataOe);
endmodule

// File: rtl/pwrfail_guard.sv
module pwrfail_guard
  import pfg_pkg::*;
#(
  parameter int     ADDR_W = 13,
  parameter int     DATA_W = 8,
  parameter longint CLK_HZ = 200000000,
  parameter int     WPT_US = 100,
  parameter int     CER_MS = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrFail,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrWdata,
  output logic              arrWe,
  input  logic [DATA_W-1:0] arrRdata,
  output logic              writeOk
);
  localparam int SYNC_STAGES = 2;

  logic        pfSync;
  pfg_strobe_t strb;

  pfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(pwrFail), .syncOut(pfSync)
  );

  pfg_ctrl #(.CLK_HZ(CLK_HZ), .WPT_US(WPT_US), .CER_MS(CER_MS)) u_ctrl (
    .clk(clk), .rstN(rstN), .pfSync(pfSync), .ceN(ceN), .weN(weN), .strb(strb)
  );

  pfg_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .arrAddr(arrAddr), .arrWdata(arrWdata), .arrWe(arrWe), .arrRdata(arrRdata)
  );

  assign writeOk = strb.wrEn;

  // R5
  strobe_needs_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> (writeOk && !ceN && !weN));
endmodule

// File: tb/pwrfail_guard_bench.sv
module pwrfail_guard_bench;
  localparam int     ADDR_W  = 13;
  localparam int     DATA_W  = 8;
  localparam longint CLK_HZ  = 100000;
  localparam int     WPT_US  = 100;
  localparam int     CER_MS  = 80;
  localparam int     WPT_CYC = int'((CLK_HZ * WPT_US) / 1000000);
  localparam int     CER_CYC = int'((CLK_HZ * CER_MS) / 1000);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrFail = 1'b1;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut, arrWdata, arrRdata;
  logic [ADDR_W-1:0] arrAddr;
  logic dataOe, arrWe, writeOk;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] arrayMem [16];
  logic [7:0] refMem [16];
  logic ceNPrevM, holdM;

  always #2.5 clk = ~clk;

  pwrfail_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_HZ(CLK_HZ),
                  .WPT_US(WPT_US), .CER_MS(CER_MS)) u_pwrfail_guard (
    .clk(clk), .rstN(rstN), .pwrFail(pwrFail), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .arrAddr(arrAddr), .arrWdata(arrWdata), .arrWe(arrWe), .arrRdata(arrRdata),
    .writeOk(writeOk)
  );

  // Array model driven only by the design's strobes.
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) arrayMem[i] <= 8'h00;
    end else if (arrWe) begin
      arrayMem[arrAddr[3:0]] <= arrWdata;
    end
  end
  assign arrRdata = arrayMem[arrAddr[3:0]];

  // Bench model of the late-select rule (R7).
  always @(posedge clk) begin
    if (!rstN) begin
      ceNPrevM <= 1'b1;
      holdM    <= 1'b0;
    end else begin
      ceNPrevM <= ceN;
      if (ceN)                    holdM <= 1'b0;
      else if (ceNPrevM && !weN)  holdM <= 1'b1;
    end
  end

  function automatic logic expWrite(logic c, logic w);
    return !c && !w;
  endfunction

  function automatic logic expRead(logic c, logic w, logic o, logic h);
    return !c && w && !o && !h;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
  endtask

  // Drops pwrFail and counts edges until writes open (R3, optional R4 probe).
  task automatic recover(string tag, bit probeRead);
    int n = 0;
    idle();
    pwrFail = 1'b0;
    while (n < CER_CYC + 50) begin
      cyc();
      n++;
      if (probeRead && n == 50) begin
        ceN = 1'b0; weN = 1'b1; oeN = 1'b0; addr = 13'd3;
        #1;
        chk("R4 read oe in recovery", dataOe, 1);
        chk("R4 read data in recovery", dataOut, refMem[3]);
      end else if (probeRead && n == 51) begin
        weN = 1'b0; dataIn = 8'h5A;
        #1;
        chk("R3 no write in recovery", arrWe, 0);
      end else if (probeRead && n == 52) begin
        idle();
      end
      #1;
      if (writeOk) break;
    end
    chk(tag, n, CER_CYC + 3);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) refMem[i] = 8'h00;
    // R1: reset with supply failed
    repeat (3) cyc();
    #1;
    chk("R1 writeOk in reset", writeOk, 0);
    chk("R1 dataOe in reset", dataOe, 0);
    rstN = 1'b1;
    repeat (3) cyc();
    ceN = 1'b0; weN = 1'b0; oeN = 1'b0; dataIn = 8'hFF;
    #1;
    chk("R1 writeOk after reset", writeOk, 0);
    chk("R2 arrWe ignored", arrWe, 0);
    cyc();
    weN = 1'b1;
    #1;
    chk("R2 dataOe ignored", dataOe, 0);
    chk("R1 dataOut zero", dataOut, 0);
    cyc(); idle();
    cyc();

    recover("R3 recovery length", 1'b1);

    // R7 directed: select falls after the strobe
    cyc(); ceN = 1'b1; weN = 1'b0; oeN = 1'b1; addr = 13'd5; dataIn = 8'hA5;
    cyc(); ceN = 1'b0;
    #1; chk("R5 write strobe", arrWe, 1);
    refMem[5] = 8'hA5;
    cyc(); weN = 1'b1; oeN = 1'b0;
    #1; chk("R7 bus stays hiz", dataOe, 0);
    cyc(); ceN = 1'b1;
    cyc(); ceN = 1'b0;
    #1; chk("R6 read after hold cleared", dataOe, 1);
    chk("R6 read data", dataOut, 8'hA5);
    cyc(); idle();

    // R5/R6/R7 random traffic
    begin
      int seed = 32'h1234;
      void'($urandom(seed));
      for (int k = 0; k < 400; k++) begin
        logic eW, eR;
        cyc();
        ceN = ($urandom % 4) == 0;
        weN = $urandom % 2;
        oeN = ($urandom % 3) == 0;
        addr = ADDR_W'($urandom % 16);
        dataIn = 8'($urandom);
        #1;
        eW = expWrite(ceN, weN);
        eR = expRead(ceN, weN, oeN, holdM);
        chk("R5 random arrWe", arrWe, eW);
        chk("R6 random dataOe", dataOe, eR);
        chk("R6 random dataOut", dataOut, eR ? refMem[addr[3:0]] : 8'h00);
        if (eW) begin
          chk("R5 addr forward", arrAddr, addr);
          chk("R5 data forward", arrWdata, dataIn);
          refMem[addr[3:0]] = dataIn;
        end
      end
    end
    cyc(); idle();
    cyc();

    // R8: power fail with no open access
    pwrFail = 1'b1;
    cyc(); cyc();
    #1; chk("R8 still open after edge 2", writeOk, 1);
    cyc();
    #1; chk("R8 closed after edge 3", writeOk, 0);
    repeat (5) cyc();
    recover("R3 recovery after R8", 1'b0);

    // R9: write in flight completes
    cyc();
    ceN = 1'b0; weN = 1'b0; addr = 13'd7; dataIn = 8'h3C; pwrFail = 1'b1;
    cyc(); cyc(); cyc(); cyc();
    #1;
    chk("R9 write continues", arrWe, 1);
    chk("R9 writeOk in drain", writeOk, 1);
    weN = 1'b1;
    cyc();
    #1;
    chk("R9 protected after strobe rise", writeOk, 0);
    weN = 1'b0;
    #1; chk("R9 no new write", arrWe, 0);
    cyc(); idle();
    repeat (3) cyc();
    recover("R3 recovery after R9", 1'b0);

    // R10: drain timeout
    cyc();
    ceN = 1'b0; weN = 1'b0; addr = 13'd8; pwrFail = 1'b1;
    repeat (WPT_CYC + 2) cyc();
    #1;
    chk("R10 open at edge WPT+2", writeOk, 1);
    chk("R10 strobe at edge WPT+2", arrWe, 1);
    cyc();
    #1;
    chk("R10 forced at edge WPT+3", writeOk, 0);
    chk("R10 strobe cut", arrWe, 0);
    cyc(); idle();
    repeat (3) cyc();
    recover("R3 recovery after R10", 1'b0);

    // R11: read in flight
    cyc();
    ceN = 1'b0; weN = 1'b1; oeN = 1'b0; addr = 13'd5; pwrFail = 1'b1;
    cyc(); cyc(); cyc();
    #1;
    chk("R11 writes closed", writeOk, 0);
    chk("R11 read continues", dataOe, 1);
    weN = 1'b0;
    #1; chk("R11 write blocked in read drain", arrWe, 0);
    weN = 1'b1;
    cyc();
    #1; chk("R11 read still on", dataOe, 1);
    ceN = 1'b1;
    cyc();
    ceN = 1'b0;
    #1; chk("R11 protected after select rise", dataOe, 0);
    cyc(); idle();
    repeat (3) cyc();

    // R12: abort recovery, then full restart
    pwrFail = 1'b0;
    repeat (100) cyc();
    #1; chk("R12 closed mid recovery", writeOk, 0);
    pwrFail = 1'b1;
    repeat (10) cyc();
    #1; chk("R12 closed after abort", writeOk, 0);
    recover("R12 full restart count", 1'b0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule